// File: doc/BRIEF.md
# Bus Address Break Comparator

This block sits beside a CPU bus with a 16-bit address and a 16-bit data path made of two byte lanes. It compares each bus access against a programmed break address and, optionally, programmed break data. When an access matches, it latches a break flag and, if enabled, drives a level interrupt request toward the CPU. The request stays up until software clears the flag.

Software reaches the block through a byte-wide register port. There are six byte registers: a control byte, a status byte, two address bytes and two data bytes. The control byte selects which kind of cycle may break (instruction fetch, data read, data write, or either data direction), the access size, and how the data is compared. The status byte holds the break flag and the interrupt enable. The flag can be cleared only by a read that returns it as 1, followed by a write of 0.

Byte accesses always carry their data on the upper lane, whatever the address parity. The data compare for a byte access therefore always uses the upper break data byte. For word accesses, the lane that is compared follows the parity of the break address.

Top module: `bus_break_unit`

## Requirements
- R1: After reset, the break address reads 0xFFFF, the control byte reads 0x00, the status byte reads 0x3F and `breakIrq` is 0. The break data bytes have no defined reset value.
- R2: The register offsets on `regAddr` are 0 control, 1 status, 2 address high byte, 3 address low byte, 4 data high byte, 5 data low byte. `regRdata` shows the selected register in the same cycle. Control bits 7:5 read 0. Status bits 5:0 always read 1, and writes to them have no effect.
- R3: Control bits 1:0 select the break cycle: 0 is an instruction fetch (`busFetch`=1), 1 is a data read (`busFetch`=0, `busWrite`=0), 2 is a data write (`busFetch`=0, `busWrite`=1), and 3 is any data cycle (`busFetch`=0). A cycle of any other kind does not match.
- R4: Control bit 2 selects the access size (0 byte, 1 word), and only accesses whose `busWord` equals this bit can match. A byte access compares all 16 address bits. A word access compares address bits 15:1.
- R5: An instruction fetch matches only when `busInstStart` marks the first byte of an instruction. For fetch breaks the data compare is skipped.
- R6: Control bits 4:3 select the data compare (0 none, 1 upper, 2 lower, 3 full). For a byte data access, any mode other than none compares `busData[15:8]` with the data high byte.
- R7: For a word data access with an even break address, mode 1 compares the upper lane with the data high byte, mode 2 compares the lower lane with the data low byte, and mode 3 compares both. With an odd break address, any mode other than none compares only the lower lane with the data low byte.
- R8: A matching access with `busValid`=1 sets the status flag (bit 7) at the next clock edge.
- R9: The flag clears only on a status write with bit 7 = 0, and only after a status read has returned the flag as 1. A write of 0 without that read leaves the flag set. A write of 1 to bit 7 has no effect.
- R10: Status bit 6 is the interrupt enable. `breakIrq` is a registered level equal to flag AND enable, and it updates at the same edge as those bits.
- R11: If a match and a valid clearing write happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | A bus access is present this cycle |
| busAddr | input | 16 | Access address |
| busData | input | 16 | Data on both byte lanes |
| busWrite | input | 1 | 1 for a write access |
| busFetch | input | 1 | 1 for an instruction fetch |
| busInstStart | input | 1 | Fetch is the first byte of an instruction |
| busWord | input | 1 | 1 for a word access, 0 for a byte access |
| regAddr | input | 3 | Register offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| breakIrq | output | 1 | Break interrupt request level |

## Verification
The assertions assume that the register strobes and the bus inputs are never unknown once reset is released. They also assume that `regRd` and `regWr` do not target the status register in the same cycle, so that the arming read and the clearing write are distinct events. The bench drives every input from a defined value at each falling edge. It never asserts a read and a write together, and it writes both break data bytes before any compare that depends on them.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int ADDR_W = 16;
  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;
  localparam int REG_AW = 3;
  localparam logic [ADDR_W-1:0] ADDR_RESET = '1;

  localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] OFS_STATUS = 3'd1;
  localparam logic [REG_AW-1:0] OFS_ADDRH  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_ADDRL  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_DATAH  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_DATAL  = 3'd5;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_RW    = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    DCMP_NONE  = 2'd0,
    DCMP_UPPER = 2'd1,
    DCMP_LOWER = 2'd2,
    DCMP_FULL  = 2'd3
  } dcmp_e;

  typedef struct packed {
    dcmp_e dmode;
    logic  word;
    cyc_e  ctype;
  } brk_cfg_t;

  typedef struct packed {
    logic              wrAddrHi;
    logic              wrAddrLo;
    logic              wrDataHi;
    logic              wrDataLo;
    logic [LANE_W-1:0] wdata;
  } brk_strobe_t;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  brk_strobe_t       strobe,
  input  brk_cfg_t          cfg,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWrite,
  input  logic              busFetch,
  input  logic              busInstStart,
  input  logic              busWord,
  output logic [ADDR_W-1:0] brkAddr,
  output logic [DATA_W-1:0] brkData,
  output logic              hit
);
  logic cycleOk, sizeOk, addrOk, dataOk, hiEq, loEq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkAddr <= ADDR_RESET;
    end else begin
      if (strobe.wrAddrHi) brkAddr[ADDR_W-1:LANE_W] <= strobe.wdata;
      if (strobe.wrAddrLo) brkAddr[LANE_W-1:0]      <= strobe.wdata;
    end
  end

  // data bytes have no defined reset value
  always_ff @(posedge clk) begin
    if (strobe.wrDataHi) brkData[DATA_W-1:LANE_W] <= strobe.wdata;
    if (strobe.wrDataLo) brkData[LANE_W-1:0]      <= strobe.wdata;
  end

  always_comb begin
    unique case (cfg.ctype)
      CYC_FETCH: cycleOk = busFetch && busInstStart;
      CYC_READ:  cycleOk = !busFetch && !busWrite;
      CYC_WRITE: cycleOk = !busFetch && busWrite;
      default:   cycleOk = !busFetch;
    endcase
  end

  assign sizeOk = (busWord == cfg.word);
  assign addrOk = busWord ? (busAddr[ADDR_W-1:1] == brkAddr[ADDR_W-1:1])
                          : (busAddr == brkAddr);
  assign hiEq = (busData[DATA_W-1:LANE_W] == brkData[DATA_W-1:LANE_W]);
  assign loEq = (busData[LANE_W-1:0] == brkData[LANE_W-1:0]);

  always_comb begin
    if (busFetch || cfg.dmode == DCMP_NONE) begin
      dataOk = 1'b1;
    end else if (!busWord) begin
      dataOk = hiEq;
    end else if (brkAddr[0]) begin
      dataOk = loEq;
    end else begin
      unique case (cfg.dmode)
        DCMP_UPPER: dataOk = hiEq;
        DCMP_LOWER: dataOk = loEq;
        default:    dataOk = hiEq && loEq;
      endcase
    end
  end

  assign hit = busValid && cycleOk && sizeOk && addrOk && dataOk;

  a_r5_fetch_first_byte: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busFetch && !busInstStart) |-> !hit);
  a_r6_byte_upper_lane: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !busWord && !busFetch && cfg.dmode != DCMP_NONE)
      |-> (busData[DATA_W-1:LANE_W] == brkData[DATA_W-1:LANE_W]));
  a_r4_size_agrees: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (busWord == cfg.word));
  a_r3_no_fetch_for_data: assert property (@(posedge clk) disable iff (!rstN)
    (hit && cfg.ctype != CYC_FETCH) |-> !busFetch);
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [LANE_W-1:0] regWdata,
  input  logic              hit,
  input  logic [ADDR_W-1:0] brkAddr,
  input  logic [DATA_W-1:0] brkData,
  output brk_strobe_t       strobe,
  output brk_cfg_t          cfg,
  output logic [LANE_W-1:0] regRdata,
  output logic              breakIrq
);
  logic flagQ, flagD, ieQ, ieD, armedQ, armedD, clrOk, statWr, statRd;

  assign statWr = regWr && (regAddr == OFS_STATUS);
  assign statRd = regRd && (regAddr == OFS_STATUS);
  assign clrOk  = statWr && !regWdata[7] && armedQ;

  assign strobe.wrAddrHi = regWr && (regAddr == OFS_ADDRH);
  assign strobe.wrAddrLo = regWr && (regAddr == OFS_ADDRL);
  assign strobe.wrDataHi = regWr && (regAddr == OFS_DATAH);
  assign strobe.wrDataLo = regWr && (regAddr == OFS_DATAL);
  assign strobe.wdata    = regWdata;

  always_comb begin
    flagD  = flagQ;
    armedD = armedQ;
    if (hit) begin
      flagD = 1'b1;
    end else if (clrOk) begin
      flagD  = 1'b0;
      armedD = 1'b0;
    end
    if (statRd && flagQ) armedD = 1'b1;
    ieD = statWr ? regWdata[6] : ieQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      ieQ      <= 1'b0;
      armedQ   <= 1'b0;
      breakIrq <= 1'b0;
      cfg      <= '{dmode: DCMP_NONE, word: 1'b0, ctype: CYC_FETCH};
    end else begin
      flagQ    <= flagD;
      ieQ      <= ieD;
      armedQ   <= armedD;
      breakIrq <= flagD && ieD;
      if (regWr && regAddr == OFS_CTRL)
        cfg <= '{dmode: dcmp_e'(regWdata[4:3]), word: regWdata[2],
                 ctype: cyc_e'(regWdata[1:0])};
    end
  end

  always_comb begin
    unique case (regAddr)
      OFS_CTRL:   regRdata = {3'b000, cfg};
      OFS_STATUS: regRdata = {flagQ, ieQ, 6'h3F};
      OFS_ADDRH:  regRdata = brkAddr[ADDR_W-1:LANE_W];
      OFS_ADDRL:  regRdata = brkAddr[LANE_W-1:0];
      OFS_DATAH:  regRdata = brkData[DATA_W-1:LANE_W];
      OFS_DATAL:  regRdata = brkData[LANE_W-1:0];
      default:    regRdata = '0;
    endcase
  end

  a_r8_hit_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> flagQ);
  a_r11_match_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hit && statWr && !regWdata[7]) |=> flagQ);
  a_r9_clear_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(armedQ && statWr && !regWdata[7]));
  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    breakIrq == (flagQ && ieQ));
  a_r2_reserved_ones: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_STATUS) |-> (regRdata[5:0] == 6'h3F));
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import brk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic [15:0] busAddr,
  input  logic [15:0] busData,
  input  logic        busWrite,
  input  logic        busFetch,
  input  logic        busInstStart,
  input  logic        busWord,
  input  logic [2:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        breakIrq
);
  brk_strobe_t       strobe;
  brk_cfg_t          cfg;
  logic              hit;
  logic [ADDR_W-1:0] brkAddr;
  logic [DATA_W-1:0] brkData;

  brk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .hit(hit), .brkAddr(brkAddr), .brkData(brkData),
    .strobe(strobe), .cfg(cfg), .regRdata(regRdata), .breakIrq(breakIrq)
  );

  brk_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg), .busValid(busValid),
    .busAddr(busAddr), .busData(busData), .busWrite(busWrite), .busFetch(busFetch),
    .busInstStart(busInstStart), .busWord(busWord), .brkAddr(brkAddr),
    .brkData(brkData), .hit(hit)
  );
endmodule

// File: tb/test_bus_break_unit.sv
module test_bus_break_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 0, busWrite = 0, busFetch = 0, busInstStart = 0, busWord = 0;
  logic [15:0] busAddr = '0, busData = '0;
  logic [2:0] regAddr = '0;
  logic regWr = 0, regRd = 0;
  logic [7:0] regWdata = '0, regRdata;
  logic breakIrq;
  int total = 0, bad = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;  // 125 MHz

  bus_break_unit i_bus_break_unit (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busWrite(busWrite), .busFetch(busFetch), .busInstStart(busInstStart),
    .busWord(busWord), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .breakIrq(breakIrq)
  );

  // {ctrl, brkAddr, brkData, accAddr, accData, {write,fetch,start,word}, expHit}
  localparam int NV = 25;
  localparam logic [76:0] VEC [0:NV-1] = '{
    {8'h00,16'h1000,16'h0000,16'h1000,16'h0000,4'b0110,1'b1},
    {8'h00,16'h1000,16'h0000,16'h1000,16'h0000,4'b0100,1'b0},
    {8'h01,16'h2001,16'h0000,16'h2001,16'h0000,4'b0000,1'b1},
    {8'h01,16'h2001,16'h0000,16'h2001,16'h0000,4'b1000,1'b0},
    {8'h02,16'h2001,16'h0000,16'h2001,16'h0000,4'b1000,1'b1},
    {8'h02,16'h2001,16'h0000,16'h2001,16'h0000,4'b0000,1'b0},
    {8'h03,16'h2001,16'h0000,16'h2001,16'h0000,4'b0000,1'b1},
    {8'h03,16'h2001,16'h0000,16'h2001,16'h0000,4'b1000,1'b1},
    {8'h03,16'h2001,16'h0000,16'h2001,16'h0000,4'b0110,1'b0},
    {8'h01,16'h2000,16'h0000,16'h2000,16'h0000,4'b0001,1'b0},
    {8'h05,16'h3000,16'h0000,16'h3001,16'h0000,4'b0001,1'b1},
    {8'h05,16'h3000,16'h0000,16'h3002,16'h0000,4'b0001,1'b0},
    {8'h01,16'h3000,16'h0000,16'h3001,16'h0000,4'b0000,1'b0},
    {8'h09,16'h4001,16'hAB00,16'h4001,16'hAB12,4'b0000,1'b1},
    {8'h09,16'h4001,16'hAB00,16'h4001,16'h12AB,4'b0000,1'b0},
    {8'h11,16'h4000,16'hAB55,16'h4000,16'hAB00,4'b0000,1'b1},
    {8'h1D,16'h5000,16'h1234,16'h5000,16'h1234,4'b0001,1'b1},
    {8'h1D,16'h5000,16'h1234,16'h5000,16'h1235,4'b0001,1'b0},
    {8'h0D,16'h5000,16'h12FF,16'h5000,16'h1200,4'b0001,1'b1},
    {8'h15,16'h5000,16'hFF34,16'h5000,16'h0034,4'b0001,1'b1},
    {8'h15,16'h5000,16'hFF34,16'h5000,16'h3400,4'b0001,1'b0},
    {8'h0D,16'h5001,16'h0034,16'h5000,16'h0034,4'b0001,1'b1},
    {8'h0D,16'h5001,16'h0034,16'h5000,16'h3400,4'b0001,1'b0},
    {8'h1E,16'h6000,16'hBEEF,16'h6000,16'hBEEF,4'b1001,1'b1},
    {8'h18,16'h7000,16'h1111,16'h7000,16'h2222,4'b0110,1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic busAccess(input logic [15:0] a, input logic [15:0] d, input logic [3:0] f);
    @(negedge clk);
    busAddr = a; busData = d; {busWrite, busFetch, busInstStart, busWord} = f;
    busValid = 1'b1;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic clearFlag();
    logic [7:0] s;
    regRead(3'd1, s);
    regWrite(3'd1, 8'h40);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    regRead(3'd2, rd); chk("R1 addr hi", {8'h0, rd}, 16'h00FF);
    regRead(3'd3, rd); chk("R1 addr lo", {8'h0, rd}, 16'h00FF);
    regRead(3'd0, rd); chk("R1 ctrl", {8'h0, rd}, 16'h0000);
    regRead(3'd1, rd); chk("R1 status", {8'h0, rd}, 16'h003F);
    chk("R1 irq", {15'h0, breakIrq}, 16'h0);
    // R2 reserved status bits and register read-back
    regWrite(3'd1, 8'h00);
    regRead(3'd1, rd); chk("R2 reserved ones", {8'h0, rd}, 16'h003F);
    regWrite(3'd0, 8'hFF);
    regRead(3'd0, rd); chk("R2 ctrl upper zero", {8'h0, rd}, 16'h001F);
    regWrite(3'd4, 8'h5A);
    regRead(3'd4, rd); chk("R2 data hi", {8'h0, rd}, 16'h005A);

    // Table walk: R3 R4 R5 R6 R7 R8 R10
    regWrite(3'd1, 8'h40);
    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      string tag;
      v = VEC[i];
      regWrite(3'd0, v[76:69]);
      regWrite(3'd2, v[68:61]);
      regWrite(3'd3, v[60:53]);
      regWrite(3'd4, v[52:45]);
      regWrite(3'd5, v[44:37]);
      clearFlag();
      busAccess(v[36:21], v[20:5], v[4:1]);
      tag = $sformatf("vector %0d R3 R4 R5 R6 R7 R8", i);
      chk(tag, {15'h0, breakIrq}, {15'h0, v[0]});
      regRead(3'd1, rd);
      chk(tag, {15'h0, rd[7]}, {15'h0, v[0]});
    end

    // R9 clear handshake
    regWrite(3'd0, 8'h01); regWrite(3'd2, 8'h80); regWrite(3'd3, 8'h00);
    clearFlag();
    regWrite(3'd1, 8'h00);          // no arming read since the clear: enable off
    busAccess(16'h8000, 16'h0, 4'b0000);
    chk("R10 irq off with enable 0", {15'h0, breakIrq}, 16'h0);
    regWrite(3'd1, 8'h00);          // write 0 without a prior read
    regRead(3'd1, rd); chk("R9 no clear without read", {8'h0, rd}, 16'h00BF);
    regWrite(3'd1, 8'h80);          // write 1 after the read
    regRead(3'd1, rd); chk("R9 write one no effect", {8'h0, rd}, 16'h00BF);
    regWrite(3'd1, 8'h40);          // now clear, enable on
    regRead(3'd1, rd); chk("R9 cleared", {8'h0, rd}, 16'h007F);
    chk("R10 irq low after clear", {15'h0, breakIrq}, 16'h0);

    // R11 match and clear together
    busAccess(16'h8000, 16'h0, 4'b0000);
    chk("R10 irq high", {15'h0, breakIrq}, 16'h1);
    regRead(3'd1, rd);
    @(negedge clk);
    regAddr = 3'd1; regWdata = 8'h40; regWr = 1'b1;
    busAddr = 16'h8000; {busWrite, busFetch, busInstStart, busWord} = 4'b0000; busValid = 1'b1;
    @(negedge clk);
    regWr = 1'b0; busValid = 1'b0;
    regRead(3'd1, rd); chk("R11 match wins", {8'h0, rd}, 16'h00FF);
    chk("R11 irq kept", {15'h0, breakIrq}, 16'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule